// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns internal reset requests into one timed system reset. Four conditions can request it:
- an undefined instruction reported by the CPU decoder;
- an instruction fetch from an address that nothing decodes;
- a supply-low indication from an analog comparator;
- an expiry pulse from the watchdog counter.

Any accepted request pulls the external reset pin low and holds the CPU in reset. The release happens in two steps. The pin is held for a long, programmable count of reference-clock cycles. The CPU reset is then kept for a short further count, so the reset vector fetch starts only once the pin has settled high.

A status register with one bit per source records why the last reset happened. Software clears the whole register with a read strobe. A separate output disables the watchdog. That output is formed purely combinationally from the high-voltage pin indications, qualified by monitor mode or a break state. A noise glitch therefore cannot latch the watchdog off.

Top module: `rstseq_top`

## Requirements
- R1: A cycle with `bad_op` high sets status bit 0 (bad instruction). In the next cycle `pin_pull` and `cpu_rst` are both high.
- R2: `stop_op` is treated exactly as `bad_op` when `stop_allow` is 0. When `stop_allow` is 1, `stop_op` has no effect.
- R3: `no_map` causes a reset and sets status bit 1 (bad fetch address) only in a cycle where `op_fetch` is also high. A data access to an unmapped address (`op_fetch` low) changes neither the outputs nor the status.
- R4: `lowv_async` passes through a two-flop synchronizer. A one-cycle pulse sets status bit 2 and starts the reset three clock edges after it is driven.
- R5: A `wdt_expire` pulse sets status bit 3 and starts the same reset sequence.
- R6: `pin_pull` stays high for exactly HOLD_CYCLES cycles after the last accepted request. The default is 4096.
- R7: `cpu_rst` stays high for TAIL_CYCLES further cycles after `pin_pull` falls (default 64), and then falls. `cpu_rst` is never low while `pin_pull` is high.
- R8: A request arriving while a sequence is active restarts the pin-hold count from zero.
- R9: Every source asserting in the same cycle is recorded. A request during an active sequence adds its bit to the status. A request while idle replaces the status with only its own bits.
- R10: A `stat_rd` pulse with no request in the same cycle clears all status bits on the next edge.
- R11: `wdog_off` is high exactly when (`mon_mode` and (`hv_rst` or `hv_irq`)) or (`brk_state` and `hv_rst`), with no register delay.
- R12: After `arst_n` is released, `pin_pull`, `cpu_rst` and the status are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | reference clock |
| arst_n | input | 1 | asynchronous power-on reset, active low |
| bad_op | input | 1 | CPU decoded an undefined instruction |
| stop_op | input | 1 | CPU decoded the STOP instruction |
| stop_allow | input | 1 | option bit: 1 permits STOP, 0 makes it illegal |
| op_fetch | input | 1 | current bus access is an opcode fetch |
| no_map | input | 1 | current access hits an unmapped address |
| lowv_async | input | 1 | asynchronous low-supply comparator output |
| wdt_expire | input | 1 | watchdog timeout pulse |
| mon_mode | input | 1 | part is in monitor mode |
| brk_state | input | 1 | part is in a break state |
| hv_rst | input | 1 | high voltage present on the reset pin |
| hv_irq | input | 1 | high voltage present on the interrupt pin |
| stat_rd | input | 1 | status register read strobe (clears all bits) |
| pin_pull | output | 1 | enables the open-drain pulldown on the reset pin |
| cpu_rst | output | 1 | holds the CPU in reset |
| wdog_off | output | 1 | disables the watchdog |
| rst_status | output | 4 | cause bits: [0] bad instruction, [1] bad fetch address, [2] low supply, [3] watchdog |

## Verification
The bench builds the block with HOLD_CYCLES = 16 and TAIL_CYCLES = 4; the synchronizer keeps its two stages. At these values every phase boundary can be sampled on both sides in a few dozen cycles. This covers the last pin-held cycle, the first tail cycle and the CPU release. The short counts also make a restart visible, since a second request lands well inside the first hold window and moves the release edge. With two synchronizer stages, the three-edge latency of the low-supply path can be checked exactly.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
   localparam int NUM_SRC     = 4;
   localparam int SRC_BADOP   = 0;
   localparam int SRC_BADADDR = 1;
   localparam int SRC_LOWV    = 2;
   localparam int SRC_WDOG    = 3;

   typedef logic [NUM_SRC-1:0] src_vec_t;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_HOLD = 2'd1,
      SEQ_TAIL = 2'd2
   } seq_state_t;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rstseq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain[0] <= 1'b0;
            else         chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain[i] <= 1'b0;
            else         chain[i] <= chain[i-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/rstseq_detect.sv
module rstseq_detect
   import rstseq_pkg::*;
(
   input  logic     bad_op,
   input  logic     stop_op,
   input  logic     stop_allow,
   input  logic     op_fetch,
   input  logic     no_map,
   input  logic     lowv_sync,
   input  logic     wdt_expire,
   output src_vec_t req
);
   logic illegal_stop;

   always_comb begin
      illegal_stop          = stop_op & ~stop_allow;
      req                   = '0;
      req[SRC_BADOP]        = bad_op | illegal_stop;
      req[SRC_BADADDR]      = no_map & op_fetch;
      req[SRC_LOWV]         = lowv_sync;
      req[SRC_WDOG]         = wdt_expire;
   end
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer
   import rstseq_pkg::*;
#(
   parameter int HOLD_CYCLES = 4096,
   parameter int TAIL_CYCLES = 64
) (
   input  logic clk,
   input  logic arst_n,
   input  logic restart,
   output logic pin_low,
   output logic cpu_hold
);
   localparam int MAXC = (HOLD_CYCLES > TAIL_CYCLES) ? HOLD_CYCLES : TAIL_CYCLES;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);
   localparam logic [CW-1:0] TAIL_LAST = CW'(TAIL_CYCLES - 1);

   if (HOLD_CYCLES < 2) begin : g_bad_hold
      $error("rstseq_timer: HOLD_CYCLES must be at least 2");
   end
   if (TAIL_CYCLES < 1) begin : g_bad_tail
      $error("rstseq_timer: TAIL_CYCLES must be at least 1");
   end

   seq_state_t      state;
   logic [CW-1:0]   cnt;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state <= SEQ_IDLE;
         cnt   <= '0;
      end else if (restart) begin
         state <= SEQ_HOLD;
         cnt   <= '0;
      end else begin
         case (state)
            SEQ_HOLD: begin
               if (cnt == HOLD_LAST) begin
                  state <= SEQ_TAIL;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SEQ_TAIL: begin
               if (cnt == TAIL_LAST) begin
                  state <= SEQ_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               state <= SEQ_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign pin_low  = (state == SEQ_HOLD);
   assign cpu_hold = (state != SEQ_IDLE);

   // R8: any request puts the pin hold back at its first cycle
   a_r8_restart_hold: assert property (@(posedge clk) disable iff (!arst_n)
      restart |=> (pin_low && cnt == '0));

   // R7: the CPU is only released after a cycle with the pin already free
   a_r7_release_order: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(cpu_hold) |-> $past(!pin_low));

   // R7: leaving the hold phase always enters the tail with the CPU still held
   a_r7_tail_follows: assert property (@(posedge clk) disable iff (!arst_n)
      ($fell(pin_low) && !$past(restart)) |-> cpu_hold);
endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
   import rstseq_pkg::*;
(
   input  logic     clk,
   input  logic     arst_n,
   input  src_vec_t req,
   input  logic     busy,
   input  logic     rd_clr,
   output src_vec_t status
);
   src_vec_t kept;

   always_comb begin
      if (rd_clr || (!busy && (|req))) kept = '0;
      else                             kept = status;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) status <= '0;
      else         status <= kept | req;
   end

   // R10: a read with no competing request empties the register
   a_r10_read_clear: assert property (@(posedge clk) disable iff (!arst_n)
      (rd_clr && !(|req)) |=> (status == '0));

   // R9: every source present in a cycle is recorded
   a_r9_all_recorded: assert property (@(posedge clk) disable iff (!arst_n)
      (|req) |=> ((status & $past(req)) == $past(req)));

   // R9: an idle-state request leaves only its own bits
   a_r9_idle_replace: assert property (@(posedge clk) disable iff (!arst_n)
      (!busy && (|req)) |=> (status == $past(req)));
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
   import rstseq_pkg::*;
#(
   parameter int HOLD_CYCLES = 4096,
   parameter int TAIL_CYCLES = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                arst_n,
   input  logic                bad_op,
   input  logic                stop_op,
   input  logic                stop_allow,
   input  logic                op_fetch,
   input  logic                no_map,
   input  logic                lowv_async,
   input  logic                wdt_expire,
   input  logic                mon_mode,
   input  logic                brk_state,
   input  logic                hv_rst,
   input  logic                hv_irq,
   input  logic                stat_rd,
   output logic                pin_pull,
   output logic                cpu_rst,
   output logic                wdog_off,
   output logic [NUM_SRC-1:0]  rst_status
);
   logic     lowv_sync;
   src_vec_t req;
   logic     any_req;

   rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .din    (lowv_async),
      .dout   (lowv_sync)
   );

   rstseq_detect u_detect (
      .bad_op     (bad_op),
      .stop_op    (stop_op),
      .stop_allow (stop_allow),
      .op_fetch   (op_fetch),
      .no_map     (no_map),
      .lowv_sync  (lowv_sync),
      .wdt_expire (wdt_expire),
      .req        (req)
   );

   assign any_req = |req;

   rstseq_timer #(.HOLD_CYCLES(HOLD_CYCLES), .TAIL_CYCLES(TAIL_CYCLES)) u_timer (
      .clk      (clk),
      .arst_n   (arst_n),
      .restart  (any_req),
      .pin_low  (pin_pull),
      .cpu_hold (cpu_rst)
   );

   rstseq_status u_status (
      .clk    (clk),
      .arst_n (arst_n),
      .req    (req),
      .busy   (cpu_rst),
      .rd_clr (stat_rd),
      .status (rst_status)
   );

   // Watchdog disable: no storage on this path so a glitch cannot stick
   assign wdog_off = (mon_mode & (hv_rst | hv_irq)) | (brk_state & hv_rst);

   // R1: an undefined instruction records its bit and starts the reset
   a_r1_badop_reset: assert property (@(posedge clk) disable iff (!arst_n)
      bad_op |=> (rst_status[SRC_BADOP] && pin_pull && cpu_rst));

   // R3: data access to an unmapped address alone never starts a reset
   a_r3_data_ignored: assert property (@(posedge clk) disable iff (!arst_n)
      (no_map && !op_fetch && !bad_op && !(stop_op && !stop_allow) &&
       !wdt_expire && !lowv_sync && !cpu_rst) |=> !cpu_rst);

   // R5: the watchdog pulse sets its own cause bit
   a_r5_wdog_bit: assert property (@(posedge clk) disable iff (!arst_n)
      wdt_expire |=> rst_status[SRC_WDOG]);

   // R7: pin pulldown implies the CPU is held
   a_r7_pin_implies_cpu: assert property (@(posedge clk) disable iff (!arst_n)
      pin_pull |-> cpu_rst);

   // R11: monitor mode with high voltage on the interrupt pin always disables
   a_r11_mon_irq: assert property (@(posedge clk) disable iff (!arst_n)
      (mon_mode && hv_irq) |-> wdog_off);

   // R11: without monitor mode or break, nothing disables the watchdog
   a_r11_no_mode: assert property (@(posedge clk) disable iff (!arst_n)
      (!mon_mode && !brk_state) |-> !wdog_off);
endmodule

// File: tb/rstseq_top_bench.sv
`timescale 1ns/1ps
module rstseq_top_bench;
   localparam int HOLD = 16;
   localparam int TAIL = 4;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic bad_op = 0, stop_op = 0, stop_allow = 1, op_fetch = 0, no_map = 0;
   logic lowv_async = 0, wdt_expire = 0, mon_mode = 0, brk_state = 0;
   logic hv_rst = 0, hv_irq = 0, stat_rd = 0;
   logic pin_pull, cpu_rst, wdog_off;
   logic [3:0] rst_status;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit mon_busy = 0;

   typedef struct {
      string      tag;
      int         dly;
      logic       pin;
      logic       cpu;
      logic       wd;
      logic [3:0] st;
   } exp_t;

   exp_t q[$];

   always #2 clk = ~clk;

   rstseq_top #(.HOLD_CYCLES(HOLD), .TAIL_CYCLES(TAIL), .SYNC_STAGES(2)) u_rstseq_top (
      .clk(clk), .arst_n(arst_n), .bad_op(bad_op), .stop_op(stop_op),
      .stop_allow(stop_allow), .op_fetch(op_fetch), .no_map(no_map),
      .lowv_async(lowv_async), .wdt_expire(wdt_expire), .mon_mode(mon_mode),
      .brk_state(brk_state), .hv_rst(hv_rst), .hv_irq(hv_irq), .stat_rd(stat_rd),
      .pin_pull(pin_pull), .cpu_rst(cpu_rst), .wdog_off(wdog_off),
      .rst_status(rst_status)
   );

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected < 20000", cycles);
         finish_run();
      end
   end

   // monitor: pops expected items and compares after the stated number of falling edges
   initial begin
      forever begin
         exp_t it;
         wait (q.size() > 0);
         it = q.pop_front();
         mon_busy = 1;
         if (it.dly > 0) repeat (it.dly) @(negedge clk);
         #1;
         checks++;
         if (pin_pull !== it.pin || cpu_rst !== it.cpu || wdog_off !== it.wd ||
             rst_status !== it.st) begin
            failures++;
            $display("FAIL %s: actual pin=%b cpu=%b wd=%b st=%b expected pin=%b cpu=%b wd=%b st=%b",
                     it.tag, pin_pull, cpu_rst, wdog_off, rst_status,
                     it.pin, it.cpu, it.wd, it.st);
         end
         mon_busy = 0;
      end
   end

   task automatic push(string tag, int dly, logic pin, logic cpu, logic wd, logic [3:0] st);
      exp_t it;
      it.tag = tag; it.dly = dly; it.pin = pin; it.cpu = cpu; it.wd = wd; it.st = st;
      q.push_back(it);
   endtask

   task automatic drain();
      wait (q.size() == 0 && !mon_busy);
   endtask

   // full sequence: first = falling edges until the pin first reads low-active
   task automatic push_seq(string tag, int first, logic [3:0] st);
      push({tag, " start"},      first,    1, 1, 0, st);
      push({tag, " last hold"},  HOLD - 1, 1, 1, 0, st);
      push({tag, " tail begin"}, 1,        0, 1, 0, st);
      push({tag, " tail end"},   TAIL - 1, 0, 1, 0, st);
      push({tag, " released"},   1,        0, 0, 0, st);
   endtask

   task automatic read_clear(string tag);
      @(negedge clk);
      stat_rd = 1;
      push(tag, 1, 0, 0, 0, 4'b0000);
      @(negedge clk);
      stat_rd = 0;
      drain();
   endtask

   task automatic wd_case(string tag, logic m, logic b, logic hr, logic hi, logic exp_wd);
      @(negedge clk);
      mon_mode = m; brk_state = b; hv_rst = hr; hv_irq = hi;
      push(tag, 0, 0, 0, exp_wd, rst_status);
      drain();
      mon_mode = 0; brk_state = 0; hv_rst = 0; hv_irq = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      arst_n = 1;

      // R12: state after power-on reset
      push("R12 reset state", 1, 0, 0, 0, 4'b0000);
      drain();

      // R1 / R6 / R7: bad instruction, full sequence
      @(negedge clk);
      bad_op = 1;
      push_seq("R1 R6 R7 bad instruction", 1, 4'b0001);
      @(negedge clk);
      bad_op = 0;
      drain();

      // R10: read clears
      read_clear("R10 read clears status");

      // R2: STOP permitted has no effect
      @(negedge clk);
      stop_allow = 1; stop_op = 1;
      push("R2 STOP allowed ignored", 1, 0, 0, 0, 4'b0000);
      @(negedge clk);
      stop_op = 0;
      drain();

      // R2: STOP forbidden acts as a bad instruction
      @(negedge clk);
      stop_allow = 0; stop_op = 1;
      push_seq("R2 STOP forbidden", 1, 4'b0001);
      @(negedge clk);
      stop_op = 0;
      drain();
      stop_allow = 1;

      // R3: data access to unmapped address ignored (status kept at bit 0)
      @(negedge clk);
      no_map = 1; op_fetch = 0;
      push("R3 data access ignored", 1, 0, 0, 0, 4'b0001);
      push("R3 data access still idle", 2, 0, 0, 0, 4'b0001);
      @(negedge clk);
      no_map = 0;
      drain();

      // R3 / R9: fetch from unmapped address; idle request replaces old bit
      @(negedge clk);
      no_map = 1; op_fetch = 1;
      push_seq("R3 R9 unmapped fetch", 1, 4'b0010);
      @(negedge clk);
      no_map = 0; op_fetch = 0;
      drain();

      // R5: watchdog timeout
      @(negedge clk);
      wdt_expire = 1;
      push_seq("R5 watchdog timeout", 1, 4'b1000);
      @(negedge clk);
      wdt_expire = 0;
      drain();
      read_clear("R10 read clears watchdog bit");

      // R9: simultaneous sources all recorded
      @(negedge clk);
      bad_op = 1; wdt_expire = 1;
      push_seq("R9 simultaneous", 1, 4'b1001);
      @(negedge clk);
      bad_op = 0; wdt_expire = 0;
      drain();
      read_clear("R10 read after simultaneous");

      // R8 / R9: restart during active sequence
      @(negedge clk);
      bad_op = 1;
      push("R8 first request", 1, 1, 1, 0, 4'b0001);
      @(negedge clk);
      bad_op = 0;
      drain();
      repeat (8) @(negedge clk);
      wdt_expire = 1;
      push_seq("R8 R9 restarted", 1, 4'b1001);
      @(negedge clk);
      wdt_expire = 0;
      drain();
      read_clear("R10 read after restart");

      // R4: low-supply pulse through the synchronizer
      @(negedge clk);
      lowv_async = 1;
      push("R4 not yet seen", 2, 0, 0, 0, 4'b0000);
      @(negedge clk);
      lowv_async = 0;
      drain();
      push_seq("R4 low supply", 1, 4'b0100);
      drain();

      // R11: watchdog disable combinations
      wd_case("R11 monitor + hv reset pin", 1, 0, 1, 0, 1);
      wd_case("R11 monitor + hv irq pin",   1, 0, 0, 1, 1);
      wd_case("R11 break + hv reset pin",   0, 1, 1, 0, 1);
      wd_case("R11 break + hv irq pin",     0, 1, 0, 1, 0);
      wd_case("R11 hv reset pin alone",     0, 0, 1, 0, 0);
      wd_case("R11 monitor without hv",     1, 0, 0, 0, 0);

      finish_run();
   end
endmodule